// File: doc/BRIEF.md
# Power State Sequencer for a Contactless Front-End

This block keeps track of which power state a contactless-interface device is in, and it drives the supply enable of the device's core logic. Each cycle it takes several inputs: an 8-bit battery level code, two programmable battery thresholds, a host enable level, a configuration bit that turns battery monitoring on, a configuration bit that allows autonomous standby, a requested operating sub-mode, and three wake-up requests. The wake-up requests come from host serial-bus activity, an RF level detector and a low-power polling timer.

The device has four states. In the battery-critical state and in the host-forced power-down state the system is off. In Standby only the wake-up logic stays alive. In Active the core is powered and runs in one of three sub-modes. Entry to the battery-critical state uses a low threshold, and exit from it uses a higher threshold. After power-up the device goes straight to Active. When the host allows it, the device drops back to Standby by itself after a programmable stretch of idle time. While the device is in Standby, it records every wake source that fires in a sticky cause register, and the host clears that register one bit at a time.

Top module: `pwr_state_seq`

## Requirements
- R1: While rst_n is low, state_oh reads 4'b0010 (power-down), core_pwr_en is 0, sub_mode is 0, wake_cause is 0 and full_pwr is 0.
- R2: state_oh is one-hot at all times: bit 0 is battery-critical, bit 1 is host power-down, bit 2 is Standby and bit 3 is Active.
- R3: If host_en is low during a cycle, state_oh is power-down after the next clock edge, whatever the battery level.
- R4: With mon_en and host_en high and the state not yet battery-critical, a batt_code strictly below thr_enter moves the state to battery-critical on the next edge.
- R5: The battery-critical state is left only when batt_code is strictly greater than thr_exit. Codes from thr_enter up to and including thr_exit keep the current state. When mon_en is low, battery level never causes battery-critical.
- R6: When the state is power-down or battery-critical and host_en is high with the battery not critical, core_pwr_en rises on the next edge while the state is unchanged, and state_oh becomes Active on the edge after that.
- R7: In Active, sub_mode follows sub_req one edge later, with 0 = Idle, 1 = Target and 2 = Initiator; a request of 3 is reported as Idle. Outside Active, sub_mode is 0.
- R8: With auto_sby high, once sub_mode first reports Idle in Active, the state stays Active for idle_limit+1 cycles and then becomes Standby. With auto_sby low, the state never moves to Standby on its own.
- R9: In Standby, a one-cycle pulse on any of wake_bus, wake_rf or wake_tmr raises core_pwr_en on the next edge, and state_oh becomes Active on the edge after that.
- R10: When the state leaves Active, core_pwr_en stays high for one more cycle and then falls, unless the state has returned to Active.
- R11: wake_cause bit 0 is bus, bit 1 is RF and bit 2 is timer. In Standby, every source that is high is latched, and simultaneous sources are all latched. Outside Standby the wake inputs are ignored. A 1 in wake_clr clears the matching bit on the next edge.
- R12: full_pwr is 1 exactly when the state is Standby or Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| batt_code | input | 8 | Digitized battery level |
| thr_enter | input | 8 | Level below which the battery is critical |
| thr_exit | input | 8 | Level the battery must exceed to leave critical (must be greater than thr_enter) |
| host_en | input | 1 | Host enable level; low forces power-down |
| mon_en | input | 1 | Battery monitoring enable |
| auto_sby | input | 1 | Allows autonomous entry to Standby |
| idle_limit | input | 16 | Idle cycles before autonomous Standby |
| sub_req | input | 2 | Requested Active sub-mode |
| wake_bus | input | 1 | Host serial-bus activity wake request |
| wake_rf | input | 1 | RF level detect wake request |
| wake_tmr | input | 1 | Low-power polling timer wake request |
| wake_clr | input | 3 | Write-one-to-clear for wake_cause bits |
| state_oh | output | 4 | One-hot state |
| sub_mode | output | 2 | Active sub-mode |
| core_pwr_en | output | 1 | Core supply enable |
| full_pwr | output | 1 | System is in full-power mode |
| wake_cause | output | 3 | Sticky wake-source record |

## Verification
The assertions check several properties on every cycle. The state must stay one-hot. A low host enable must force power-down on the next edge. Any rise of Active must be preceded by an active core supply. The battery-critical state must hold while the level stays at or below the exit threshold. The wake-cause bits must latch in Standby and hold elsewhere when no clear is requested. Only the bench scenarios can show the rest: exact arrival times (the idle_limit+1 window before autonomous Standby, the one-cycle supply lag after leaving Active), the decoding of sub-modes, and the behaviour of simultaneous wake sources.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [3:0] {
    ST_CRIT = 4'b0001,
    ST_PDN  = 4'b0010,
    ST_SBY  = 4'b0100,
    ST_ACT  = 4'b1000
  } pwr_state_e;

  typedef enum logic [1:0] {
    SM_IDLE = 2'd0,
    SM_TGT  = 2'd1,
    SM_INIT = 2'd2
  } sub_mode_e;

  localparam int unsigned NUM_WAKE = 3;
endpackage

// File: rtl/batt_hyst.sv
module batt_hyst #(
  parameter int unsigned BATT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic [BATT_W-1:0] batt_code,
  input  logic [BATT_W-1:0] thr_enter,
  input  logic [BATT_W-1:0] thr_exit,
  output logic              crit
);
  logic low_q;
  logic low_d;

  always_comb begin
    if (!mon_en)    low_d = 1'b0;
    else if (low_q) low_d = (batt_code <= thr_exit);
    else            low_d = (batt_code < thr_enter);
  end

  assign crit = low_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_d;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = run && (cnt_q >= limit);
  assign cnt_en = !run || !done;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wake_latch.sv
module wake_latch #(
  parameter int unsigned NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sby,
  input  logic [NW-1:0] wake_in,
  input  logic [NW-1:0] clr,
  output logic [NW-1:0] cause,
  output logic          any_wake
);
  logic [NW-1:0] cause_d;

  for (genvar i = 0; i < NW; i++) begin : g_bit
    assign cause_d[i] = (in_sby && wake_in[i]) ? 1'b1 :
                        (clr[i] ? 1'b0 : cause[i]);
  end

  assign any_wake = in_sby && (|wake_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= cause_d;
  end

  // R11: a source seen in Standby is recorded on the next edge
  a_r11_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sby && wake_in[0]) |=> cause[0]);
  // R11: outside Standby and with no clear, the record holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sby && clr == '0) |=> $stable(cause));
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_state_pkg::*;
#(
  parameter int unsigned BATT_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BATT_W-1:0] batt_code,
  input  logic [BATT_W-1:0] thr_enter,
  input  logic [BATT_W-1:0] thr_exit,
  input  logic              host_en,
  input  logic              mon_en,
  input  logic              auto_sby,
  input  logic [CNT_W-1:0]  idle_limit,
  input  logic [1:0]        sub_req,
  input  logic              wake_bus,
  input  logic              wake_rf,
  input  logic              wake_tmr,
  input  logic [2:0]        wake_clr,
  output logic [3:0]        state_oh,
  output logic [1:0]        sub_mode,
  output logic              core_pwr_en,
  output logic              full_pwr,
  output logic [2:0]        wake_cause
);
  pwr_state_e state_q, state_d, tgt;
  sub_mode_e  sub_q, sub_d, sub_dec;
  logic       core_q, core_d;
  logic       pend_q, pend_d;
  logic       crit, idle_done, any_wake, idle_run;
  logic [NUM_WAKE-1:0] wake_vec;

  assign wake_vec = {wake_tmr, wake_rf, wake_bus};
  assign idle_run = (state_q == ST_ACT) && (sub_q == SM_IDLE);

  batt_hyst #(.BATT_W(BATT_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .batt_code(batt_code),
    .thr_enter(thr_enter), .thr_exit(thr_exit), .crit(crit)
  );

  idle_timer #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .run(idle_run), .limit(idle_limit),
    .done(idle_done)
  );

  wake_latch #(.NW(NUM_WAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .in_sby(state_q == ST_SBY),
    .wake_in(wake_vec), .clr(wake_clr), .cause(wake_cause),
    .any_wake(any_wake)
  );

  always_comb begin
    case (sub_req)
      2'd1:    sub_dec = SM_TGT;
      2'd2:    sub_dec = SM_INIT;
      default: sub_dec = SM_IDLE;
    endcase
  end

  // target state, highest priority first
  always_comb begin
    if (!host_en)   tgt = ST_PDN;
    else if (crit)  tgt = ST_CRIT;
    else begin
      case (state_q)
        ST_SBY:  tgt = (any_wake || pend_q) ? ST_ACT : ST_SBY;
        ST_ACT:  tgt = (auto_sby && idle_done) ? ST_SBY : ST_ACT;
        default: tgt = ST_ACT;
      endcase
    end
  end

  // Active is reached only once the core supply is already up
  always_comb begin
    state_d = ((tgt == ST_ACT) && !core_q) ? state_q : tgt;
    core_d  = (tgt == ST_ACT) || (state_q == ST_ACT);
    pend_d  = (tgt == ST_ACT) && (state_q != ST_ACT);
    sub_d   = (state_d == ST_ACT) ? sub_dec : SM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PDN;
      sub_q   <= SM_IDLE;
      core_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      core_q  <= core_d;
      pend_q  <= pend_d;
    end
  end

  assign state_oh    = state_q;
  assign sub_mode    = sub_q;
  assign core_pwr_en = core_q;
  assign full_pwr    = state_q[2] | state_q[3];

  // R2: exactly one state bit set
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);
  // R3: host enable low forces power-down
  a_r3_host_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> state_oh == 4'b0010);
  // R6, R9: core supply already up when Active begins
  a_r9_core_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_oh[3]) |-> $past(core_pwr_en));
  // R5: critical state holds until the exit level is exceeded
  a_r5_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh == 4'b0001 && host_en && mon_en && batt_code <= thr_exit)
      |=> state_oh == 4'b0001);
  // R10: core supply still up in the first cycle after Active ends
  a_r10_core_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_oh[3]) |-> core_pwr_en);
endmodule

// File: tb/pwr_state_seq_tb.sv
module pwr_state_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] batt_code, thr_enter, thr_exit;
  logic       host_en, mon_en, auto_sby;
  logic [15:0] idle_limit;
  logic [1:0] sub_req;
  logic       wake_bus, wake_rf, wake_tmr;
  logic [2:0] wake_clr;
  logic [3:0] state_oh;
  logic [1:0] sub_mode;
  logic       core_pwr_en, full_pwr;
  logic [2:0] wake_cause;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] CRIT = 4'b0001, PDN = 4'b0010, SBY = 4'b0100, ACT = 4'b1000;

  always #2 clk = ~clk;

  pwr_state_seq u_dut (
    .clk(clk), .rst_n(rst_n), .batt_code(batt_code), .thr_enter(thr_enter),
    .thr_exit(thr_exit), .host_en(host_en), .mon_en(mon_en),
    .auto_sby(auto_sby), .idle_limit(idle_limit), .sub_req(sub_req),
    .wake_bus(wake_bus), .wake_rf(wake_rf), .wake_tmr(wake_tmr),
    .wake_clr(wake_clr), .state_oh(state_oh), .sub_mode(sub_mode),
    .core_pwr_en(core_pwr_en), .full_pwr(full_pwr), .wake_cause(wake_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic go_active();
    host_en = 1'b1; batt_code = 8'd200;
    step(2);
    chk("R6 active", state_oh, ACT);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    batt_code = 8'd200; thr_enter = 8'd50; thr_exit = 8'd80;
    host_en = 1'b1; mon_en = 1'b1; auto_sby = 1'b0; idle_limit = 16'd5;
    sub_req = 2'd0; wake_bus = 0; wake_rf = 0; wake_tmr = 0; wake_clr = 3'b0;
    step(3);
    chk("R1 state", state_oh, PDN);
    chk("R1 core", core_pwr_en, 1'b0);
    chk("R1 sub", sub_mode, 2'd0);
    chk("R1 cause", wake_cause, 3'b0);
    chk("R1 full_pwr", full_pwr, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_boot();
    step(1);
    chk("R6 state held", state_oh, PDN);
    chk("R6 core early", core_pwr_en, 1'b1);
    step(1);
    chk("R6 active", state_oh, ACT);
    chk("R12 full_pwr", full_pwr, 1'b1);
  endtask

  task automatic t_submode();
    sub_req = 2'd1; step(1); chk("R7 target", sub_mode, 2'd1);
    sub_req = 2'd2; step(1); chk("R7 initiator", sub_mode, 2'd2);
    sub_req = 2'd3; step(1); chk("R7 code3 idle", sub_mode, 2'd0);
    sub_req = 2'd0;
  endtask

  task automatic t_hostdown();
    host_en = 1'b0; batt_code = 8'd10;
    step(1);
    chk("R3 power-down", state_oh, PDN);
    chk("R10 core lag", core_pwr_en, 1'b1);
    chk("R7 sub outside active", sub_mode, 2'd0);
    step(1);
    chk("R10 core off", core_pwr_en, 1'b0);
    chk("R12 full_pwr off", full_pwr, 1'b0);
    go_active();
  endtask

  task automatic t_monitor();
    batt_code = 8'd40; step(1);
    chk("R4 enter critical", state_oh, CRIT);
    step(1);
    chk("R10 core off in critical", core_pwr_en, 1'b0);
    batt_code = 8'd60; step(3);
    chk("R5 hold mid", state_oh, CRIT);
    batt_code = 8'd80; step(2);
    chk("R5 hold at exit", state_oh, CRIT);
    batt_code = 8'd81; step(1);
    chk("R6 still critical", state_oh, CRIT);
    chk("R6 core rises", core_pwr_en, 1'b1);
    step(1);
    chk("R5 left critical", state_oh, ACT);
    batt_code = 8'd60; step(2);
    chk("R5 mid keeps active", state_oh, ACT);
    mon_en = 1'b0; batt_code = 8'd10; step(3);
    chk("R5 monitor off", state_oh, ACT);
    mon_en = 1'b1; batt_code = 8'd200;
  endtask

  task automatic t_auto_off();
    auto_sby = 1'b0; sub_req = 2'd0; step(20);
    chk("R8 no auto standby", state_oh, ACT);
  endtask

  task automatic t_auto_sby();
    sub_req = 2'd1; step(2);
    sub_req = 2'd0; auto_sby = 1'b1; idle_limit = 16'd5;
    step(1);
    chk("R8 idle reported", sub_mode, 2'd0);
    step(5);
    chk("R8 still active", state_oh, ACT);
    step(1);
    chk("R8 standby", state_oh, SBY);
    chk("R10 core lag", core_pwr_en, 1'b1);
    chk("R12 full in standby", full_pwr, 1'b1);
    step(1);
    chk("R10 core off", core_pwr_en, 1'b0);
    chk("R8 stays standby", state_oh, SBY);
  endtask

  task automatic t_wake();
    auto_sby = 1'b0;
    wake_rf = 1'b1; wake_tmr = 1'b1;
    step(1);
    wake_rf = 1'b0; wake_tmr = 1'b0;
    chk("R9 core first", core_pwr_en, 1'b1);
    chk("R9 still standby", state_oh, SBY);
    chk("R11 both latched", wake_cause, 3'b110);
    step(1);
    chk("R9 active", state_oh, ACT);
    wake_clr = 3'b010; step(1); wake_clr = 3'b000;
    chk("R11 clear rf", wake_cause, 3'b100);
    wake_bus = 1'b1; step(1); wake_bus = 1'b0;
    chk("R11 ignored outside standby", wake_cause, 3'b100);
    wake_clr = 3'b100; step(1); wake_clr = 3'b000;
    chk("R11 clear timer", wake_cause, 3'b000);
  endtask

  task automatic t_wake_bus();
    sub_req = 2'd1; step(1);
    sub_req = 2'd0; auto_sby = 1'b1; idle_limit = 16'd0;
    step(3);
    chk("R8 limit zero standby", state_oh, SBY);
    auto_sby = 1'b0; step(4);
    chk("R9 no wake stays", state_oh, SBY);
    wake_bus = 1'b1; step(1); wake_bus = 1'b0;
    chk("R11 bus latched", wake_cause, 3'b001);
    step(1);
    chk("R9 bus wake active", state_oh, ACT);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_submode();
    t_hostdown();
    t_monitor();
    t_auto_off();
    t_auto_sby();
    t_wake();
    t_wake_bus();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule